// File: doc/BRIEF.md
# Boot Strap Memory Alias Decoder

This block sits between a processor's read port and two on-chip flash banks: bank 0 holds the user application and bank 1 holds the system bootloader. Reads in a low window that starts at address zero are steered to one of the two banks. Each bank can also be reached at its own fixed base address. The processor reads its vector table through the low window, so the bank chosen for that window decides which image runs.

The window's bank is fixed once per reset. A strap pin is latched on the first clock after external reset is released. When the strap asks for the application, a small sequencer first reads the first four words of bank 0. If the reset-vector word (word index 1) is all ones, the application is treated as absent and the window is redirected to the bootloader bank. The processor's reset output stays asserted until this decision is made. Every read has one cycle of latency. Addresses that match neither the window nor a bank range return zero and raise an error strobe.

Top module: `boot_alias_decoder`

## Requirements
- R1: Once the core is running, a read at byte address A with A below the bank size (1024 bytes by default) returns word A[9:2] of the bank given by `alias_bank_o`: bank 0 when it is 0 and bank 1 when it is 1.
- R2: A read at 0x0800_0000 + off returns bank 0 word off[9:2`], and a read at 0x0900_0000 + off returns bank 1 word off[9:2], for any off below the bank size and whatever the window selection. Address bit 24 picks the bank.
- R3: When the window selects bank 0, reads at A and at 0x0800_0000 + A return identical data.
- R4: The strap is sampled only on the first clock edge at which `rst` is low. Changing the strap later has no effect on `alias_bank_o` or on window reads until the next reset.
- R5: With the strap at 0, the block reads bank 0 words 0, 1, 2 and 3, in that order, while the core is held. If word 1 equals 0xFFFF_FFFF, `alias_bank_o` becomes 1. Otherwise it stays 0. The values of the other words do not affect the choice.
- R6: `core_rst_o` is high during reset. It falls after the 6th clock edge that samples `rst` low when the strap is 0, and after the 2nd such edge when the strap is 1.
- R7: A read request accepted on one clock edge gives `core_rvalid_o` high, with its data, during the following cycle only.
- R8: A read that hits neither the window nor a bank range gives `core_rvalid_o` high, `core_rdata_o` = 0 and `core_err_o` high for exactly one cycle. A bank range covers only the bank size above its base address.
- R9: While `core_rst_o` is high, core requests are ignored: the block returns no read-valid and no error, and it drives no read request to bank 1.
- R10: `alias_bank_o` reports the bank the window resolved to (0 = application, 1 = bootloader).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| strap_i | input | 1 | Boot strap: 0 = application, 1 = bootloader |
| core_req_i | input | 1 | Core read request |
| core_addr_i | input | 32 | Core byte address |
| core_rvalid_o | output | 1 | Read data valid |
| core_rdata_o | output | 32 | Read data |
| core_err_o | output | 1 | Unmapped-address strobe |
| core_rst_o | output | 1 | Reset to the core, high while held |
| alias_bank_o | output | 1 | Bank selected for the low window |
| b0_req_o | output | 1 | Bank 0 read request |
| b0_addr_o | output | 8 | Bank 0 word index |
| b0_rdata_i | input | 32 | Bank 0 data, one cycle after request |
| b1_req_o | output | 1 | Bank 1 read request |
| b1_addr_o | output | 8 | Bank 1 word index |
| b1_rdata_i | input | 32 | Bank 1 data, one cycle after request |

## Verification
The bench boots four times. The first boot has the strap low and a valid application. The second has the strap high. The third has the strap low with word 1 blanked, and the fourth has the strap low with only word 0 blanked. Comparing the second and third boots shows that the strap path and the blank path both reach the bootloader. The fourth boot shows that only the vector word is tested. Within one boot, window, direct and out-of-range reads are mixed so that a wrong bank choice, a wrong offset mask or a missing error can each be told apart. Toggling the strap after release and driving requests during the hold cover the latch and the ignore rules.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;
    localparam int ADDR_W_DEF    = 32;
    localparam int DATA_W_DEF    = 32;
    localparam int WORD_BITS_DEF = 8;
    localparam int CHECK_WORDS   = 4;
    localparam int CHECK_IDX     = 1;
    localparam int SEL_BIT_DEF   = 24;
    localparam logic [31:0] BANK_BASE_DEF = 32'h0800_0000;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_READ,
        ST_DECIDE,
        ST_RUN
    } boot_state_e;
endpackage

// File: rtl/boot_alias_fsm.sv
module boot_alias_fsm
    import boot_alias_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int WORD_BITS = WORD_BITS_DEF,
    parameter int N_WORDS   = CHECK_WORDS,
    parameter int VEC_IDX   = CHECK_IDX
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strap_i,
    input  logic [DATA_W-1:0]    app_rdata_i,
    output logic                 rd_req_o,
    output logic [WORD_BITS-1:0] rd_word_o,
    output logic                 run_o,
    output logic                 alias_bank_o
);
    localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    boot_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             pend_q;
    logic             blank_q;
    logic             strap_q;
    logic             alias_q;
    logic             blank_now;

    assign rd_req_o     = (state_q == ST_READ);
    assign rd_word_o    = WORD_BITS'(idx_q);
    assign run_o        = (state_q == ST_RUN);
    assign alias_bank_o = alias_q;
    assign blank_now    = (pend_q && pend_idx_q == IDX_W'(VEC_IDX)) ? (&app_rdata_i) : blank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HOLD;
            idx_q      <= '0;
            pend_idx_q <= '0;
            pend_q     <= 1'b0;
            blank_q    <= 1'b0;
            strap_q    <= 1'b0;
            alias_q    <= 1'b0;
        end else begin
            pend_q     <= rd_req_o;
            pend_idx_q <= idx_q;
            if (pend_q && pend_idx_q == IDX_W'(VEC_IDX))
                blank_q <= &app_rdata_i;
            case (state_q)
                ST_HOLD: begin
                    strap_q <= strap_i;
                    idx_q   <= '0;
                    state_q <= strap_i ? ST_DECIDE : ST_READ;
                end
                ST_READ: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(N_WORDS - 1))
                        state_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    alias_q <= strap_q | blank_now;
                    state_q <= ST_RUN;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // R4: window choice frozen while running
    p_alias_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> $stable(alias_q));
    // R5: check reads walk upward then hand over to the decision
    p_check_order_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> (rd_req_o ? (rd_word_o == $past(rd_word_o) + 1'b1) : (state_q == ST_DECIDE)));
    // R5: a blank vector forces the bootloader bank
    p_blank_to_boot_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECIDE && blank_now) |=> alias_q);
    // R6: release only follows the decision step
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> $past(state_q) == ST_DECIDE);
endmodule

// File: rtl/boot_alias_dec.sv
module boot_alias_dec
    import boot_alias_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int WORD_BITS = WORD_BITS_DEF,
    parameter int SEL_BIT   = SEL_BIT_DEF,
    parameter logic [ADDR_W-1:0] BANK_BASE = ADDR_W'(BANK_BASE_DEF)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_i,
    input  logic                 alias_bank_i,
    input  logic                 core_req_i,
    input  logic [ADDR_W-1:0]    core_addr_i,
    input  logic                 fsm_req_i,
    input  logic [WORD_BITS-1:0] fsm_word_i,
    input  logic [DATA_W-1:0]    b0_rdata_i,
    input  logic [DATA_W-1:0]    b1_rdata_i,
    output logic [1:0]           bank_req_o,
    output logic [WORD_BITS-1:0] bank_addr_o [2],
    output logic                 core_rvalid_o,
    output logic [DATA_W-1:0]    core_rdata_o,
    output logic                 core_err_o
);
    localparam int BYTE_BITS = WORD_BITS + 2;

    typedef struct packed {
        logic                 hit;
        logic                 bank;
        logic [WORD_BITS-1:0] word;
    } dec_t;

    dec_t dec;
    logic accept;
    logic in_window;
    logic in_region;
    logic rv_q, err_q, bank_q;
    logic unused_addr;

    assign unused_addr = ^core_addr_i[1:0];
    assign accept      = run_i & core_req_i;
    assign in_window   = (core_addr_i[ADDR_W-1:BYTE_BITS] == '0);
    assign in_region   = (core_addr_i[ADDR_W-1:SEL_BIT+1] == BANK_BASE[ADDR_W-1:SEL_BIT+1])
                       && (core_addr_i[SEL_BIT-1:BYTE_BITS] == '0);

    always_comb begin
        dec.word = core_addr_i[BYTE_BITS-1:2];
        dec.hit  = in_window | in_region;
        dec.bank = in_window ? alias_bank_i : core_addr_i[SEL_BIT];
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic own;
        assign own            = (g == 0) && fsm_req_i;
        assign bank_req_o[g]  = own | (accept & dec.hit & (dec.bank == 1'(g)));
        assign bank_addr_o[g] = own ? fsm_word_i : dec.word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q   <= 1'b0;
            err_q  <= 1'b0;
            bank_q <= 1'b0;
        end else begin
            rv_q   <= accept;
            err_q  <= accept & ~dec.hit;
            bank_q <= dec.bank;
        end
    end

    assign core_rvalid_o = rv_q;
    assign core_err_o    = err_q;
    assign core_rdata_o  = (rv_q && !err_q) ? (bank_q ? b1_rdata_i : b0_rdata_i) : '0;

    // R2: never both banks in one cycle
    p_one_bank_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_req_o));
    // R7: accepted request answered next cycle
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (run_i && core_req_i) |=> core_rvalid_o);
    // R8: error carries zero data and a valid
    p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
        core_err_o |-> (core_rvalid_o && core_rdata_o == '0));
    // R9: no answer to requests made during the hold
    p_hold_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !core_rvalid_o);
endmodule

// File: rtl/boot_alias_decoder.sv
module boot_alias_decoder
    import boot_alias_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int WORD_BITS = WORD_BITS_DEF,
    parameter int SEL_BIT   = SEL_BIT_DEF,
    parameter logic [ADDR_W-1:0] BANK_BASE = ADDR_W'(BANK_BASE_DEF)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strap_i,
    input  logic                 core_req_i,
    input  logic [ADDR_W-1:0]    core_addr_i,
    output logic                 core_rvalid_o,
    output logic [DATA_W-1:0]    core_rdata_o,
    output logic                 core_err_o,
    output logic                 core_rst_o,
    output logic                 alias_bank_o,
    output logic                 b0_req_o,
    output logic [WORD_BITS-1:0] b0_addr_o,
    input  logic [DATA_W-1:0]    b0_rdata_i,
    output logic                 b1_req_o,
    output logic [WORD_BITS-1:0] b1_addr_o,
    input  logic [DATA_W-1:0]    b1_rdata_i
);
    logic                 run;
    logic                 alias_bank;
    logic                 fsm_req;
    logic [WORD_BITS-1:0] fsm_word;
    logic [1:0]           bank_req;
    logic [WORD_BITS-1:0] bank_addr [2];

    boot_alias_fsm #(
        .DATA_W    (DATA_W),
        .WORD_BITS (WORD_BITS),
        .N_WORDS   (CHECK_WORDS),
        .VEC_IDX   (CHECK_IDX)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .strap_i      (strap_i),
        .app_rdata_i  (b0_rdata_i),
        .rd_req_o     (fsm_req),
        .rd_word_o    (fsm_word),
        .run_o        (run),
        .alias_bank_o (alias_bank)
    );

    boot_alias_dec #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .WORD_BITS (WORD_BITS),
        .SEL_BIT   (SEL_BIT),
        .BANK_BASE (BANK_BASE)
    ) u_dec (
        .clk           (clk),
        .rst           (rst),
        .run_i         (run),
        .alias_bank_i  (alias_bank),
        .core_req_i    (core_req_i),
        .core_addr_i   (core_addr_i),
        .fsm_req_i     (fsm_req),
        .fsm_word_i    (fsm_word),
        .b0_rdata_i    (b0_rdata_i),
        .b1_rdata_i    (b1_rdata_i),
        .bank_req_o    (bank_req),
        .bank_addr_o   (bank_addr),
        .core_rvalid_o (core_rvalid_o),
        .core_rdata_o  (core_rdata_o),
        .core_err_o    (core_err_o)
    );

    assign core_rst_o   = ~run;
    assign alias_bank_o = alias_bank;
    assign b0_req_o     = bank_req[0];
    assign b0_addr_o    = bank_addr[0];
    assign b1_req_o     = bank_req[1];
    assign b1_addr_o    = bank_addr[1];

    // R9: bootloader bank untouched by the core while held
    p_hold_no_b1_r9: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> !b1_req_o);
endmodule

// File: tb/boot_alias_decoder_bench.sv
`timescale 1ns/1ps
module boot_alias_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap = 1'b0;
    logic        core_req = 1'b0;
    logic [31:0] core_addr = '0;
    logic        core_rvalid, core_err, core_rst, alias_bank;
    logic [31:0] core_rdata;
    logic        b0_req, b1_req;
    logic [7:0]  b0_addr, b1_addr;
    logic [31:0] b0_rdata = '0, b1_rdata = '0;
    logic [31:0] mem0 [256];
    logic [31:0] mem1 [256];

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] q_data [$];
    logic        q_err  [$];
    string       q_tag  [$];

    always #5 clk = ~clk;

    boot_alias_decoder u_boot_alias_decoder (
        .clk(clk), .rst(rst), .strap_i(strap),
        .core_req_i(core_req), .core_addr_i(core_addr),
        .core_rvalid_o(core_rvalid), .core_rdata_o(core_rdata), .core_err_o(core_err),
        .core_rst_o(core_rst), .alias_bank_o(alias_bank),
        .b0_req_o(b0_req), .b0_addr_o(b0_addr), .b0_rdata_i(b0_rdata),
        .b1_req_o(b1_req), .b1_addr_o(b1_addr), .b1_rdata_i(b1_rdata)
    );

    always @(posedge clk) begin
        if (b0_req) b0_rdata <= mem0[b0_addr];
        if (b1_req) b1_rdata <= mem1[b1_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        if (!rst && core_rvalid) begin
            if (q_data.size() == 0) begin
                chk(0, "R9 unexpected read-valid", {31'b0, core_rvalid}, 32'h0);
            end else begin
                logic [31:0] ed;
                logic        ee;
                string       et;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                chk(core_rdata == ed, {et, " data"}, core_rdata, ed);
                chk(core_err == ee, {et, " err"}, {31'b0, core_err}, {31'b0, ee});
            end
        end else if (!rst && core_err) begin
            chk(0, "R8 error without valid", 32'h1, 32'h0);
        end
    end

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            mem0[i] = 32'hA000_0000 + i;
            mem1[i] = 32'hB000_0000 + i;
        end
    endtask

    task automatic do_read(input logic [31:0] addr, input logic [31:0] exp, input logic experr, input string tag);
        @(negedge clk);
        core_req  = 1'b1;
        core_addr = addr;
        q_data.push_back(exp);
        q_err.push_back(experr);
        q_tag.push_back(tag);
        @(negedge clk);
        core_req = 1'b0;
        #1;
        chk(q_data.size() == 0, "R7 response one cycle after request", q_data.size(), 0);
        @(negedge clk);
        chk(!core_rvalid && !core_err, "R8/R7 single-cycle response", {30'b0, core_rvalid, core_err}, 0);
    endtask

    task automatic do_reset(input logic s, input int exp_cycles, input logic exp_bank, input string tag);
        int cyc;
        int nrd;
        bit b1_seen;
        bit order_ok;
        @(negedge clk);
        rst = 1'b1;
        core_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(core_rst && !core_rvalid && !core_err, {tag, " reset state R6"}, {29'b0, core_rst, core_rvalid, core_err}, 32'h4);
        strap = s;
        rst = 1'b0;
        core_req = 1'b1;
        core_addr = 32'h0900_0000;
        cyc = 0; nrd = 0; b1_seen = 0; order_ok = 1;
        while (core_rst && cyc < 50) begin
            if (b0_req) begin
                if (b0_addr != 8'(nrd)) order_ok = 0;
                nrd++;
            end
            if (b1_req) b1_seen = 1;
            @(negedge clk);
            cyc++;
        end
        core_req = 1'b0;
        chk(cyc == exp_cycles, {tag, " R6 hold length"}, cyc, exp_cycles);
        chk(!b1_seen, {tag, " R9 no bank1 access in hold"}, {31'b0, b1_seen}, 0);
        if (!s) chk(nrd == 4 && order_ok, {tag, " R5 words 0..3 read"}, nrd, 4);
        @(negedge clk);
        chk(alias_bank == exp_bank, {tag, " R10 alias flag"}, {31'b0, alias_bank}, {31'b0, exp_bank});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        fill_mem();
        // boot A: strap 0, valid application
        do_reset(1'b0, 6, 1'b0, "bootA");
        do_read(32'h0000_0000, 32'hA000_0000, 1'b0, "R1 window word0 bank0");
        do_read(32'h0800_0000, 32'hA000_0000, 1'b0, "R3 direct bank0 same as window");
        do_read(32'h0000_0024, 32'hA000_0009, 1'b0, "R3 window word9");
        do_read(32'h0800_0024, 32'hA000_0009, 1'b0, "R3 direct word9");
        do_read(32'h0000_03FC, 32'hA000_00FF, 1'b0, "R1 window last word");
        do_read(32'h0900_0008, 32'hB000_0002, 1'b0, "R2 direct bank1");
        do_read(32'h0800_03FC, 32'hA000_00FF, 1'b0, "R2 direct bank0 last");
        do_read(32'h0000_0400, 32'h0, 1'b1, "R8 past window");
        do_read(32'h0800_0400, 32'h0, 1'b1, "R8 past bank0 range");
        do_read(32'h2000_0000, 32'h0, 1'b1, "R8 unmapped high");
        strap = 1'b1;
        do_read(32'h0000_0004, 32'hA000_0001, 1'b0, "R4 strap change ignored");
        chk(alias_bank == 1'b0, "R4 flag after strap change", {31'b0, alias_bank}, 0);
        // boot B: strap 1
        do_reset(1'b1, 2, 1'b1, "bootB");
        do_read(32'h0000_0008, 32'hB000_0002, 1'b0, "R1 window to bank1");
        do_read(32'h0800_0008, 32'hA000_0002, 1'b0, "R2 bank0 still direct");
        strap = 1'b0;
        do_read(32'h0000_000C, 32'hB000_0003, 1'b0, "R4 strap drop ignored");
        // boot C: strap 0, vector word blank
        mem0[1] = 32'hFFFF_FFFF;
        do_reset(1'b0, 6, 1'b1, "bootC R5 blank");
        do_read(32'h0000_0004, 32'hB000_0001, 1'b0, "R5 blank sends window to bank1");
        do_read(32'h0800_0004, 32'hFFFF_FFFF, 1'b0, "R2 blank word direct");
        // boot D: only word 0 blank
        fill_mem();
        mem0[0] = 32'hFFFF_FFFF;
        do_reset(1'b0, 6, 1'b0, "bootD R5 word0 only");
        do_read(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, "R5 window stays on bank0");
        repeat (3) @(negedge clk);
        chk(q_data.size() == 0, "R7 no outstanding items", q_data.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule